// File: doc/BRIEF.md
# Quadword Move Decoder and Executor

This block takes a window of eight instruction bytes and decodes the quadword-move family of SIMD instructions. It then carries out the transfer in the same cycle. It holds eight 64-bit multimedia registers and sixteen 128-bit vector registers. A single 64-bit memory port serves operands that are not registers, and the address of such an operand arrives on its own input. Byte 0 of the window sits in bits 7:0, byte 1 in bits 15:8, and so on. The ModRM byte is laid out as mod in bits 7:6, reg in bits 5:3 and r/m in bits 2:0.

The decoder accepts up to four legacy prefixes (66h, F3h). In 64-bit mode it then accepts one REX byte (40h-4Fh). It then expects either the 0Fh escape byte or a vector-extension prefix (C5h with one payload byte, or C4h with two), followed by the opcode and the ModRM byte. The mandatory prefix picks the register class: none, 66h or F3h, or the pp field of the vector prefix. An encoding that is not recognised raises a combinational invalid-opcode flag and leaves every register untouched, with no memory access.

A memory read is issued in the instruction cycle, and its data is written back at the end of the following cycle. The next instruction may arrive in that following cycle. In that case the loaded value is forwarded to any read of the register being filled.

Top module: `qmov_unit`

## Requirements
- R1: After reset every multimedia and vector register reads zero, and ud_flag and mem_req are low.
- R2: 0F 6F with no mandatory prefix and no vector prefix writes multimedia register reg from multimedia register r/m (mod=11b). For any other mod, it issues a read at operand_addr (mem_req=1, mem_wr=0) and writes mem_rdata, sampled in the following cycle, at the end of that cycle.
- R3: 0F 7F with no mandatory prefix copies multimedia register reg into multimedia register r/m (mod=11b). For any other mod, it drives mem_req=1, mem_wr=1, mem_addr=operand_addr and mem_wdata equal to the register, during the instruction cycle.
- R4: F3 0F 7E, or a vector prefix with pp=10b and opcode 7E, puts bits 63:0 of vector register r/m, or the memory quadword, into bits 63:0 of vector register reg and clears bits 127:64.
- R5: 66 0F D6, or a vector prefix with pp=01b and opcode D6, moves bits 63:0 of vector register reg into vector register r/m with bits 127:64 cleared (mod=11b), or writes them to memory.
- R6: In 64-bit mode a REX byte 40h-4Fh adds 8 to the reg index of the vector forms when bit 2 is set, and adds 8 to the r/m index when bit 0 is set. Outside 64-bit mode such a byte is not a prefix, and the inverted R/B bits of a vector prefix are ignored.
- R7: The vector prefix C5h carries {~R, ~vvvv, L, pp} in byte 1. C4h carries {~R, ~X, ~B, map[4:0]} in byte 1 and {W, ~vvvv, L, pp} in byte 2. The form is legal only when the vvvv bits are all ones, L=0 and map=00001b. W is ignored.
- R8: ud_flag is high in the instruction cycle, with no register write and no memory access, when any of the following holds: a vector prefix has an illegal field; a vector prefix follows a legacy or REX prefix; the escape byte is missing; or the opcode and mandatory prefix match none of the four forms.
- R9: When a load writeback falls in the cycle of a new instruction, a read of the register being filled returns mem_rdata, and a write to that same register by the new instruction takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction window is valid this cycle |
| instr_bytes | input | 64 | Instruction bytes, byte 0 in bits 7:0 |
| long_mode | input | 1 | 64-bit mode |
| operand_addr | input | AW | Address of a memory operand |
| mem_req | output | 1 | Memory access request |
| mem_wr | output | 1 | Request is a write |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | 64 | Store data |
| mem_rdata | input | 64 | Load data, valid the cycle after a read request |
| ud_flag | output | 1 | Invalid opcode for the current window |
| mm_peek_idx | input | 3 | Multimedia register observation index |
| mm_peek_data | output | 64 | Multimedia register contents |
| vr_peek_idx | input | 4 | Vector register observation index |
| vr_peek_data | output | 128 | Vector register contents |

## Verification
The writeback of a memory load and the execution of a new instruction can fall in the same cycle. The bench provokes this by issuing a load and, in the very next cycle, an instruction that reads, stores or overwrites the register still being filled. It does this for both the multimedia and the vector class. The outcome is judged at the ports: the forwarded quadword must appear on the store data or in the copied register, and the later instruction's value must remain in a register that both write.

// File: rtl/qmov_pkg.sv
package qmov_pkg;
  localparam int NIB  = 8;          // bytes in the instruction window
  localparam int IBW  = NIB * 8;
  localparam int QW   = 64;         // quadword width
  localparam int VW   = 2 * QW;     // vector register width
  localparam int NMM  = 8;
  localparam int NVR  = 16;
  localparam int MMI  = $clog2(NMM);
  localparam int VRI  = $clog2(NVR);
  localparam int MAX_LEG = 4;       // legacy prefixes scanned

  localparam logic [7:0] PFX_OPSZ = 8'h66;
  localparam logic [7:0] PFX_REP  = 8'hF3;
  localparam logic [7:0] ESC      = 8'h0F;
  localparam logic [7:0] VEX2     = 8'hC5;
  localparam logic [7:0] VEX3     = 8'hC4;

  typedef enum logic [1:0] {K_MM_LD, K_MM_ST, K_VEC_LD, K_VEC_ST} kind_e;

  typedef struct packed {
    logic        ud;
    kind_e       kind;
    logic [3:0]  reg_idx;
    logic [3:0]  rm_idx;
    logic        rm_mem;
  } dec_t;

  function automatic logic [7:0] byte_at(input logic [IBW-1:0] w, input logic [3:0] k);
    byte_at = (k < 4'(NIB)) ? w[{k[2:0], 3'b000} +: 8] : 8'h00;
  endfunction

  function automatic logic [VW-1:0] vec_fill(input logic [QW-1:0] q);
    vec_fill = {{(VW-QW){1'b0}}, q};
  endfunction
endpackage

// File: rtl/qmov_decoder.sv
module qmov_decoder import qmov_pkg::*; (
  input  logic [IBW-1:0] bytes_i,
  input  logic           long_mode_i,
  output dec_t           dec_o
);
  logic [3:0] p;
  logic [7:0] c, opc, modrm;
  logic       stop, pf66, pfF3, has_rex, rex_r, rex_b;
  logic       vex, v_r, v_b, map_ok, v_l, esc_ok;
  logic [3:0] vvvv;
  logic [1:0] vpp, mp;
  logic       r_ext, b_ext, vex_bad, hit;

  always_comb begin
    p = '0; stop = 1'b0; pf66 = 1'b0; pfF3 = 1'b0;
    has_rex = 1'b0; rex_r = 1'b0; rex_b = 1'b0;
    vex = 1'b0; v_r = 1'b0; v_b = 1'b0; map_ok = 1'b1; v_l = 1'b0;
    vvvv = 4'hF; vpp = 2'b00; esc_ok = 1'b1;
    for (int i = 0; i < MAX_LEG; i++) begin
      c = byte_at(bytes_i, p);
      if (!stop && c == PFX_OPSZ) begin pf66 = 1'b1; p = p + 4'd1; end
      else if (!stop && c == PFX_REP) begin pfF3 = 1'b1; p = p + 4'd1; end
      else stop = 1'b1;
    end
    c = byte_at(bytes_i, p);
    if (long_mode_i && c[7:4] == 4'h4) begin
      has_rex = 1'b1; rex_r = c[2]; rex_b = c[0]; p = p + 4'd1;
    end
    c = byte_at(bytes_i, p);
    if (c == VEX2) begin
      vex = 1'b1;
      c = byte_at(bytes_i, p + 4'd1);
      v_r = ~c[7]; vvvv = c[6:3]; v_l = c[2]; vpp = c[1:0];
      p = p + 4'd2;
    end else if (c == VEX3) begin
      vex = 1'b1;
      c = byte_at(bytes_i, p + 4'd1);
      v_r = ~c[7]; v_b = ~c[5]; map_ok = (c[4:0] == 5'd1);
      c = byte_at(bytes_i, p + 4'd2);
      vvvv = c[6:3]; v_l = c[2]; vpp = c[1:0];
      p = p + 4'd3;
    end else if (c == ESC) begin
      p = p + 4'd1;
    end else begin
      esc_ok = 1'b0;
    end
    opc   = byte_at(bytes_i, p);
    modrm = byte_at(bytes_i, p + 4'd1);

    mp      = vex ? vpp : (pfF3 ? 2'b10 : (pf66 ? 2'b01 : 2'b00));
    r_ext   = long_mode_i & (vex ? v_r : rex_r);
    b_ext   = long_mode_i & (vex ? v_b : rex_b);
    vex_bad = vex & (pf66 | pfF3 | has_rex | ~map_ok | (vvvv != 4'hF) | v_l);

    hit        = 1'b1;
    dec_o.kind = K_MM_LD;
    if (!vex && mp == 2'b00 && opc == 8'h6F)      dec_o.kind = K_MM_LD;
    else if (!vex && mp == 2'b00 && opc == 8'h7F) dec_o.kind = K_MM_ST;
    else if (mp == 2'b10 && opc == 8'h7E)         dec_o.kind = K_VEC_LD;
    else if (mp == 2'b01 && opc == 8'hD6)         dec_o.kind = K_VEC_ST;
    else hit = 1'b0;

    dec_o.ud      = ~esc_ok | vex_bad | ~hit;
    dec_o.reg_idx = {r_ext, modrm[5:3]};
    dec_o.rm_idx  = {b_ext, modrm[2:0]};
    dec_o.rm_mem  = (modrm[7:6] != 2'b11);
  end
endmodule

// File: rtl/qmov_regfile.sv
module qmov_regfile #(
  parameter int N   = 8,
  parameter int W   = 64,
  parameter int RDW = 64,
  localparam int IW = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [IW-1:0]  rd_idx,
  output logic [RDW-1:0] rd_data,
  input  logic [IW-1:0]  pk_idx,
  output logic [W-1:0]   pk_data,
  input  logic           wa_en,     // load writeback
  input  logic [IW-1:0]  wa_idx,
  input  logic [W-1:0]   wa_data,
  input  logic           wb_en,     // instruction write, takes precedence
  input  logic [IW-1:0]  wb_idx,
  input  logic [W-1:0]   wb_data
);
  logic [W-1:0] rf [N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) rf[i] <= '0;
    end else begin
      if (wa_en) rf[wa_idx] <= wa_data;
      if (wb_en) rf[wb_idx] <= wb_data;
    end
  end

  assign rd_data = rf[rd_idx][RDW-1:0];
  assign pk_data = rf[pk_idx];
endmodule

// File: rtl/qmov_unit.sv
module qmov_unit import qmov_pkg::*; #(
  parameter int AW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           instr_valid,
  input  logic [IBW-1:0] instr_bytes,
  input  logic           long_mode,
  input  logic [AW-1:0]  operand_addr,
  output logic           mem_req,
  output logic           mem_wr,
  output logic [AW-1:0]  mem_addr,
  output logic [QW-1:0]  mem_wdata,
  input  logic [QW-1:0]  mem_rdata,
  output logic           ud_flag,
  input  logic [MMI-1:0] mm_peek_idx,
  output logic [QW-1:0]  mm_peek_data,
  input  logic [VRI-1:0] vr_peek_idx,
  output logic [VW-1:0]  vr_peek_data
);
  dec_t dec;
  logic is_vec, is_ld, go, ld_issue, st_issue;
  logic ld_wb, ld_vec, ins_wr, ins_wr_mm, ins_wr_vec, fwd_mm, fwd_vr;
  logic [3:0] ld_idx, src_idx, dst_idx;
  logic [QW-1:0] mm_raw, vr_raw, src_q;

  qmov_decoder u_dec (.bytes_i(instr_bytes), .long_mode_i(long_mode), .dec_o(dec));

  assign is_vec   = (dec.kind == K_VEC_LD) || (dec.kind == K_VEC_ST);
  assign is_ld    = (dec.kind == K_MM_LD)  || (dec.kind == K_VEC_LD);
  assign go       = instr_valid & ~dec.ud;
  assign ud_flag  = instr_valid & dec.ud;
  assign ld_issue = go & is_ld & dec.rm_mem;
  assign st_issue = go & ~is_ld & dec.rm_mem;

  assign src_idx  = is_ld ? dec.rm_idx : dec.reg_idx;
  assign dst_idx  = is_ld ? dec.reg_idx : dec.rm_idx;

  // forwarding of a load that completes in this cycle
  assign fwd_mm   = ld_wb & ~ld_vec & (ld_idx[2:0] == src_idx[2:0]);
  assign fwd_vr   = ld_wb &  ld_vec & (ld_idx == src_idx);
  assign src_q    = is_vec ? (fwd_vr ? mem_rdata : vr_raw) : (fwd_mm ? mem_rdata : mm_raw);

  assign ins_wr     = go & ~dec.rm_mem;
  assign ins_wr_mm  = ins_wr & ~is_vec;
  assign ins_wr_vec = ins_wr &  is_vec;

  assign mem_req   = ld_issue | st_issue;
  assign mem_wr    = st_issue;
  assign mem_addr  = operand_addr;
  assign mem_wdata = src_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ld_wb  <= 1'b0;
      ld_vec <= 1'b0;
      ld_idx <= '0;
    end else begin
      ld_wb <= ld_issue;
      if (ld_issue) begin
        ld_vec <= is_vec;
        ld_idx <= is_vec ? dec.reg_idx : {1'b0, dec.reg_idx[2:0]};
      end
    end
  end

  qmov_regfile #(.N(NMM), .W(QW), .RDW(QW)) u_mm (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(src_idx[MMI-1:0]), .rd_data(mm_raw),
    .pk_idx(mm_peek_idx), .pk_data(mm_peek_data),
    .wa_en(ld_wb & ~ld_vec), .wa_idx(ld_idx[MMI-1:0]), .wa_data(mem_rdata),
    .wb_en(ins_wr_mm), .wb_idx(dst_idx[MMI-1:0]), .wb_data(src_q)
  );

  qmov_regfile #(.N(NVR), .W(VW), .RDW(QW)) u_vr (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(src_idx[VRI-1:0]), .rd_data(vr_raw),
    .pk_idx(vr_peek_idx), .pk_data(vr_peek_data),
    .wa_en(ld_wb & ld_vec), .wa_idx(ld_idx[VRI-1:0]), .wa_data(vec_fill(mem_rdata)),
    .wb_en(ins_wr_vec), .wb_idx(dst_idx[VRI-1:0]), .wb_data(vec_fill(src_q))
  );
endmodule

// File: rtl/qmov_unit_chk.sv
module qmov_unit_chk (
  input logic clk,
  input logic rst_n,
  input logic instr_valid,
  input logic ud_flag,
  input logic mem_req,
  input logic mem_wr,
  input logic ld_wb,
  input logic ins_wr_mm,
  input logic ins_wr_vec
);
  // R8: invalid opcode leaves memory and registers alone
  p_ud_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ud_flag |-> (!mem_req && !ins_wr_mm && !ins_wr_vec));

  // R8: flag only with a presented window
  p_ud_on_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ud_flag |-> instr_valid);

  // R3: memory traffic only in an instruction cycle
  p_mem_on_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> instr_valid);

  // R2: a read request is written back in the next cycle
  p_load_wb_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_wr) |=> ld_wb);

  // R2: no writeback without a preceding read request
  p_wb_has_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_wb |-> $past(mem_req && !mem_wr));
endmodule

bind qmov_unit qmov_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .ud_flag(ud_flag),
  .mem_req(mem_req), .mem_wr(mem_wr), .ld_wb(ld_wb),
  .ins_wr_mm(ins_wr_mm), .ins_wr_vec(ins_wr_vec)
);

// File: tb/qmov_unit_tb.sv
module qmov_unit_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         instr_valid = 1'b0;
  logic [63:0]  instr_bytes = '0;
  logic         long_mode = 1'b1;
  logic [31:0]  operand_addr = '0;
  logic         mem_req, mem_wr, ud_flag;
  logic [31:0]  mem_addr;
  logic [63:0]  mem_wdata;
  logic [63:0]  mem_rdata = '0;
  logic [2:0]   mm_peek_idx = '0;
  logic [63:0]  mm_peek_data;
  logic [3:0]   vr_peek_idx = '0;
  logic [127:0] vr_peek_data;

  always #10 clk = ~clk;   // 50 MHz

  qmov_unit u_dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_bytes(instr_bytes),
    .long_mode(long_mode), .operand_addr(operand_addr),
    .mem_req(mem_req), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .ud_flag(ud_flag),
    .mm_peek_idx(mm_peek_idx), .mm_peek_data(mm_peek_data),
    .vr_peek_idx(vr_peek_idx), .vr_peek_data(vr_peek_data)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [63:0] mm_m [8];
  logic [63:0] vr_m [16];
  logic [63:0] mem_m [logic [31:0]];

  typedef struct { logic [31:0] a; logic [63:0] d; string tag; } exp_t;
  exp_t exp_q [$];

  function automatic logic [63:0] pat(input logic [31:0] a);
    return {a ^ 32'hA5A5_5A5A, a * 32'd3 + 32'd1};
  endfunction

  function automatic logic [63:0] rdmem(input logic [31:0] a);
    return mem_m.exists(a) ? mem_m[a] : pat(a);
  endfunction

  function automatic logic [7:0] mr(input int md, input int rg, input int rm);
    return {md[1:0], rg[2:0], rm[2:0]};
  endfunction

  function automatic logic [63:0] ib(input logic [7:0] b0, input logic [7:0] b1,
      input logic [7:0] b2 = 8'h00, input logic [7:0] b3 = 8'h00, input logic [7:0] b4 = 8'h00,
      input logic [7:0] b5 = 8'h00, input logic [7:0] b6 = 8'h00, input logic [7:0] b7 = 8'h00);
    return {b7, b6, b5, b4, b3, b2, b1, b0};
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // memory responder and store scoreboard monitor
  always @(posedge clk) begin
    if (rst_n && mem_req && !mem_wr) mem_rdata <= rdmem(mem_addr);
    if (rst_n && mem_req && mem_wr) begin
      if (exp_q.size() == 0) begin
        chk("unexpected store", {96'h0, mem_addr}, 128'h0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk({e.tag, " addr"}, {96'h0, mem_addr}, {96'h0, e.a});
        chk({e.tag, " data"}, {64'h0, mem_wdata}, {64'h0, e.d});
      end
      mem_m[mem_addr] = mem_wdata;
    end
  end

  task automatic push_st(input logic [31:0] a, input logic [63:0] d, input string tag);
    exp_t e;
    e.a = a; e.d = d; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // drive one instruction for one cycle; starts and ends at a falling edge
  task automatic op(input logic [63:0] b, input logic [31:0] a, input logic lm, input string tag);
    instr_bytes = b; operand_addr = a; long_mode = lm; instr_valid = 1'b1;
    #2;
    chk({tag, " ud low"}, {127'h0, ud_flag}, 128'h0);
    @(posedge clk); @(negedge clk);
    instr_valid = 1'b0; instr_bytes = '0;
  endtask

  task automatic op_ud(input logic [63:0] b, input logic lm, input string tag);
    instr_bytes = b; operand_addr = 32'hDEAD_0000; long_mode = lm; instr_valid = 1'b1;
    #2;
    chk({tag, " ud high"}, {127'h0, ud_flag}, {127'h0, 1'b1});
    chk({tag, " no access"}, {127'h0, mem_req}, 128'h0);
    @(posedge clk); @(negedge clk);
    instr_valid = 1'b0; instr_bytes = '0;
  endtask

  task automatic idle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < 8; i++) begin
      mm_peek_idx = i[2:0]; #1;
      chk($sformatf("%s mm%0d", tag, i), {64'h0, mm_peek_data}, {64'h0, mm_m[i]});
    end
    for (int i = 0; i < 16; i++) begin
      vr_peek_idx = i[3:0]; #1;
      chk($sformatf("%s vr%0d", tag, i), vr_peek_data, {64'h0, vr_m[i]});
    end
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected done");
      finish_up();
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) mm_m[i] = '0;
    for (int i = 0; i < 16; i++) vr_m[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R1: reset state
    chk("R1 ud_flag", {127'h0, ud_flag}, 128'h0);
    chk("R1 mem_req", {127'h0, mem_req}, 128'h0);
    sweep("R1 reset");

    // R2: loads from memory and register move
    op(ib(8'h0F, 8'h6F, mr(0, 2, 0)), 32'h0000_1000, 1'b1, "R2 ld mm2"); idle();
    mm_m[2] = pat(32'h0000_1000);
    op(ib(8'h0F, 8'h6F, mr(1, 5, 3)), 32'h0000_2008, 1'b1, "R2 ld mm5"); idle();
    mm_m[5] = pat(32'h0000_2008);
    op(ib(8'h0F, 8'h6F, mr(3, 0, 5)), 32'h0, 1'b1, "R2 mm0<-mm5");
    mm_m[0] = mm_m[5];
    // R3: store to register and to memory
    op(ib(8'h0F, 8'h7F, mr(3, 2, 7)), 32'h0, 1'b1, "R3 mm7<-mm2");
    mm_m[7] = mm_m[2];
    push_st(32'h0000_3000, mm_m[5], "R3 store mm5");
    op(ib(8'h0F, 8'h7F, mr(0, 5, 0)), 32'h0000_3000, 1'b1, "R3 st mm5");
    sweep("R2 R3");

    // R4: vector loads, R6: REX.R reaches vr9
    op(ib(8'hF3, 8'h0F, 8'h7E, mr(0, 1, 0)), 32'h0000_4000, 1'b1, "R4 ld vr1"); idle();
    vr_m[1] = pat(32'h0000_4000);
    op(ib(8'hF3, 8'h44, 8'h0F, 8'h7E, mr(0, 1, 0)), 32'h0000_9000, 1'b1, "R6 ld vr9"); idle();
    vr_m[9] = pat(32'h0000_9000);
    op(ib(8'hF3, 8'h0F, 8'h7E, mr(3, 3, 1)), 32'h0, 1'b1, "R4 vr3<-vr1");
    vr_m[3] = vr_m[1];
    op(ib(8'hF3, 8'h41, 8'h0F, 8'h7E, mr(3, 4, 1)), 32'h0, 1'b1, "R6 vr4<-vr9 rex.b");
    vr_m[4] = vr_m[9];
    // R5: reverse form register and memory
    op(ib(8'h66, 8'h44, 8'h0F, 8'hD6, mr(3, 1, 6)), 32'h0, 1'b1, "R5 vr6<-vr9");
    vr_m[6] = vr_m[9];
    push_st(32'h0000_A000, vr_m[3], "R5 store vr3");
    op(ib(8'h66, 8'h0F, 8'hD6, mr(0, 3, 0)), 32'h0000_A000, 1'b1, "R5 st vr3");
    sweep("R4 R5 R6");

    // R7: vector-prefixed forms, W ignored
    op(ib(8'hC5, 8'hFA, 8'h7E, mr(3, 5, 4)), 32'h0, 1'b1, "R7 c5 vr5<-vr4");
    vr_m[5] = vr_m[4];
    op(ib(8'hC5, 8'h7A, 8'h7E, mr(3, 5, 1)), 32'h0, 1'b1, "R7 c5 R vr13<-vr1");
    vr_m[13] = vr_m[1];
    op(ib(8'hC4, 8'hC1, 8'hF9, 8'hD6, mr(3, 1, 0)), 32'h0, 1'b1, "R7 c4 vr8<-vr1");
    vr_m[8] = vr_m[1];
    // R6: outside 64-bit mode the R bit is ignored
    op(ib(8'hC5, 8'h7A, 8'h7E, mr(3, 2, 6)), 32'h0, 1'b0, "R6 legacy vr2<-vr6");
    vr_m[2] = vr_m[6];
    sweep("R6 R7");

    // R8: invalid encodings
    op_ud(ib(8'hC5, 8'hF2, 8'h7E, mr(0, 1, 0)), 1'b1, "R8 vvvv");
    op_ud(ib(8'hC5, 8'hFE, 8'h7E, mr(3, 1, 0)), 1'b1, "R8 L=1");
    op_ud(ib(8'hC4, 8'hE2, 8'h79, 8'hD6, mr(3, 1, 0)), 1'b1, "R8 map");
    op_ud(ib(8'h66, 8'h0F, 8'h6F, mr(3, 1, 0)), 1'b1, "R8 66 6F");
    op_ud(ib(8'hC5, 8'hF8, 8'h6F, mr(0, 1, 0)), 1'b1, "R8 vex 6F");
    op_ud(ib(8'h0F, 8'h10, mr(3, 1, 0)), 1'b1, "R8 opcode");
    op_ud(ib(8'hF3, 8'h44, 8'h0F, 8'h7E, mr(3, 1, 0)), 1'b0, "R8 R6 rex out of mode");
    op_ud(ib(8'h66, 8'hC5, 8'hF9, 8'hD6, mr(0, 1, 0)), 1'b1, "R8 prefix+vex");
    op_ud(ib(8'h66, 8'h0F, 8'h7E, mr(3, 1, 2)), 1'b1, "R8 66 7E");
    op_ud(ib(8'hF3, 8'h7E, mr(3, 1, 2)), 1'b1, "R8 no escape");
    sweep("R8 untouched");

    // R9: load writeback coincides with the next instruction
    push_st(32'h0000_7000, pat(32'h0000_6000), "R9 fwd store mm3");
    op(ib(8'h0F, 8'h6F, mr(0, 3, 0)), 32'h0000_6000, 1'b1, "R9 ld mm3");
    op(ib(8'h0F, 8'h7F, mr(0, 3, 0)), 32'h0000_7000, 1'b1, "R9 st mm3");
    idle();
    mm_m[3] = pat(32'h0000_6000);
    op(ib(8'hF3, 8'h0F, 8'h7E, mr(0, 7, 0)), 32'h0000_5000, 1'b1, "R9 ld vr7");
    op(ib(8'hF3, 8'h44, 8'h0F, 8'h7E, mr(3, 2, 7)), 32'h0, 1'b1, "R9 vr10<-vr7");
    idle();
    vr_m[7] = pat(32'h0000_5000);
    vr_m[10] = vr_m[7];
    op(ib(8'hF3, 8'h44, 8'h0F, 8'h7E, mr(0, 3, 0)), 32'h0000_8000, 1'b1, "R9 ld vr11");
    op(ib(8'hF3, 8'h44, 8'h0F, 8'h7E, mr(3, 3, 1)), 32'h0, 1'b1, "R9 vr11<-vr1 wins");
    idle();
    vr_m[11] = vr_m[1];
    sweep("R9");
    chk("R9 R3 R5 stores drained", {96'h0, 32'(exp_q.size())}, 128'h0);

    finish_up();
  end
endmodule